// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

A purely combinational shift and rotate unit for the second-operand path of a compact processor datapath. It takes a data word, an 8-bit shift count and a two-bit operation code. It returns the shifted or rotated word, a carry-out bit and a flag that says whether that carry-out is a freshly computed value. The operations are logical left shift, logical right shift and rotate right. A fourth code passes the word through.

The surrounding core decodes instructions, holds the flag register and supplies the current carry on `carry_i`. It asserts `flag_upd_i` when the instruction may write the carry. When the update is not allowed, or when the count is zero, the unit returns the incoming carry unchanged. The core can then write `carry_o` back without further muxing.

Top module: `shc_shifter`

## Requirements
- R1: For op code 2'b00 (left shift) and a count n of 1 to 31, the result is the operand shifted up by n, with the low n bits zero.
- R2: For op 2'b00 with the update enabled and n from 1 to 32, the carry-out is operand bit[32-n], the last bit pushed out of the top.
- R3: A count of 0 with any op code gives a result equal to the operand, a carry-out equal to `carry_i` and `carry_vld_o` low.
- R4: For op 2'b00 or 2'b01 with a count of 32 or more, every result bit is 0.
- R5: For op 2'b00 or 2'b01 with a count of 33 or more and the update enabled, the carry-out is 0.
- R6: For op code 2'b01 (right shift) and n from 1 to 32, the top n result bits are zero and the rest is the operand moved down by n. With the update enabled, the carry-out is operand bit[n-1].
- R7: For op code 2'b10 (rotate right), the result is the operand rotated right by n mod 32. With the update enabled and n nonzero, the carry-out is operand bit[(n-1) mod 32].
- R8: For op 2'b10 and a nonzero count that is a multiple of 32, the result equals the operand. With the update enabled, the carry-out is operand bit[31].
- R9: With `flag_upd_i` low, `carry_o` equals `carry_i` and `carry_vld_o` is low, whatever the op code and count.
- R10: `carry_vld_o` is high exactly when `flag_upd_i` is high, the count is nonzero and the op code is not 2'b11.
- R11: Op code 2'b11 passes the operand to the result unchanged and returns `carry_i` as the carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand word |
| amt_i | input | 8 | Shift or rotate count, 0 to 255 |
| op_i | input | 2 | 00 left shift, 01 right shift, 10 rotate right, 11 pass |
| carry_i | input | 1 | Current carry flag from the core |
| flag_upd_i | input | 1 | Carry may be written by this operation |
| result_o | output | 32 | Shifted or rotated word |
| carry_o | output | 1 | Carry value to write back |
| carry_vld_o | output | 1 | High when `carry_o` is newly computed |

## Verification
The unit holds no state, so any fault shows at the ports in the same cycle as the stimulus that exposes it. A wrong rotate stage, fill mask or carry tap corrupts the result or the carry only for certain count ranges. For that reason every count from 0 to 255 is applied for each op code, each update setting and a spread of operands. The counts 0, 31, 32 and 33 are where the carry and fill rules change. A fault at any of these boundaries shows up as a single wrong cycle.

// File: rtl/shc_pkg.sv
package shc_pkg;
   typedef enum logic [1:0] {
      SHC_LSL  = 2'b00,
      SHC_LSR  = 2'b01,
      SHC_ROR  = 2'b10,
      SHC_PASS = 2'b11
   } shc_op_e;
endpackage

// File: rtl/shc_rotator.sv
// Logarithmic right rotator: one stage per bit of the rotate count.
module shc_rotator #(
   parameter int WIDTH = 32,
   localparam int LOG2W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic [LOG2W-1:0] rot_i,
   output logic [WIDTH-1:0] data_o
);
   logic [LOG2W:0][WIDTH-1:0] stage;

   assign stage[0] = data_i;

   for (genvar s = 0; s < LOG2W; s++) begin : g_stage
      localparam int STEP = 2 ** s;
      assign stage[s+1] = rot_i[s]
                          ? {stage[s][STEP-1:0], stage[s][WIDTH-1:STEP]}
                          : stage[s];
   end

   assign data_o = stage[LOG2W];
endmodule

// File: rtl/shc_mask_gen.sv
// Builds the keep mask that zero-fills vacated positions after rotation.
module shc_mask_gen
   import shc_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8,
   localparam int CW = AMT_W + 2
) (
   input  shc_op_e          op_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic [WIDTH-1:0] keep_o
);
   logic [CW-1:0] amt_ext;
   assign amt_ext = CW'(amt_i);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic keep_left;
      logic keep_right;
      // left shift keeps bit i when i >= n; right shift keeps it when i + n < WIDTH
      assign keep_left  = (CW'(i) >= amt_ext);
      assign keep_right = ((amt_ext + CW'(i)) < CW'(WIDTH));

      always_comb begin
         unique case (op_i)
            SHC_LSL: keep_o[i] = keep_left;
            SHC_LSR: keep_o[i] = keep_right;
            default: keep_o[i] = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/shc_carry_sel.sv
// Chooses the carry-out from the rotator's edge bits and the count range.
module shc_carry_sel
   import shc_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8,
   localparam int CW = AMT_W + 2
) (
   input  shc_op_e          op_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             carry_i,
   input  logic             upd_i,
   input  logic             rot_lsb_i,
   input  logic             rot_msb_i,
   output logic             carry_o,
   output logic             valid_o
);
   logic amt_zero;
   logic beyond;

   assign amt_zero = (amt_i == '0);
   assign beyond   = (CW'(amt_i) > CW'(WIDTH));
   assign valid_o  = upd_i && !amt_zero && (op_i != SHC_PASS);

   always_comb begin
      carry_o = carry_i;
      if (valid_o) begin
         unique case (op_i)
            SHC_LSL: carry_o = beyond ? 1'b0 : rot_lsb_i;
            SHC_LSR: carry_o = beyond ? 1'b0 : rot_msb_i;
            SHC_ROR: carry_o = rot_msb_i;
            default: carry_o = carry_i;
         endcase
      end
   end
endmodule

// File: rtl/shc_shifter.sv
module shc_shifter
   import shc_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8,
   localparam int LOG2W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] opnd_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic [1:0]       op_i,
   input  logic             carry_i,
   input  logic             flag_upd_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             carry_vld_o
);
   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("shc_shifter: WIDTH must be a power of two of at least 2");
   end
   if (AMT_W < LOG2W + 1) begin : g_bad_amt
      $error("shc_shifter: AMT_W too narrow to express counts up to WIDTH");
   end

   shc_op_e          op;
   logic [LOG2W-1:0] amt_low;
   logic [LOG2W-1:0] rot_amt;
   logic [WIDTH-1:0] rotated;
   logic [WIDTH-1:0] keep;

   assign op      = shc_op_e'(op_i);
   assign amt_low = amt_i[LOG2W-1:0];

   // a left shift by n is a right rotation by (WIDTH - n) mod WIDTH
   always_comb begin
      unique case (op)
         SHC_LSL:          rot_amt = '0 - amt_low;
         SHC_LSR, SHC_ROR: rot_amt = amt_low;
         default:          rot_amt = '0;
      endcase
   end

   shc_rotator #(.WIDTH(WIDTH)) rot_i (
      .data_i (opnd_i),
      .rot_i  (rot_amt),
      .data_o (rotated)
   );

   shc_mask_gen #(.WIDTH(WIDTH), .AMT_W(AMT_W)) mask_i (
      .op_i   (op),
      .amt_i  (amt_i),
      .keep_o (keep)
   );

   shc_carry_sel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) carry_sel_i (
      .op_i      (op),
      .amt_i     (amt_i),
      .carry_i   (carry_i),
      .upd_i     (flag_upd_i),
      .rot_lsb_i (rotated[0]),
      .rot_msb_i (rotated[WIDTH-1]),
      .carry_o   (carry_o),
      .valid_o   (carry_vld_o)
   );

   assign result_o = rotated & keep;
endmodule

// File: rtl/shc_shifter_chk.sv
module shc_shifter_chk #(
   parameter int WIDTH = 32,
   parameter int AMT_W = 8
) (
   input logic [WIDTH-1:0] opnd_i,
   input logic [AMT_W-1:0] amt_i,
   input logic [1:0]       op_i,
   input logic             carry_i,
   input logic             flag_upd_i,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_o,
   input logic             carry_vld_o
);
   logic known;
   assign known = !$isunknown({opnd_i, amt_i, op_i, carry_i, flag_upd_i});

   always_comb begin
      if (known) begin
         // R9: no update means the carry is passed straight back
         p_carry_hold_r9: assert (flag_upd_i || (carry_o == carry_i && !carry_vld_o))
            else $error("carry changed with update disabled");
         // R3: zero count is an identity on data and carry
         p_zero_amt_r3: assert (amt_i != '0 || (result_o == opnd_i && carry_o == carry_i))
            else $error("zero count altered data or carry");
         // R4: shifts of WIDTH or more clear the word
         p_big_clear_r4: assert (op_i[1] || int'(amt_i) < WIDTH || result_o == '0)
            else $error("large shift left bits set");
         // R5: shifts beyond WIDTH with update give carry 0
         p_big_carry_r5: assert (op_i[1] || !flag_upd_i || int'(amt_i) <= WIDTH || !carry_o)
            else $error("large shift produced carry");
         // R7: rotation preserves the population count
         p_ror_pop_r7: assert (op_i != 2'b10 || $countones(result_o) == $countones(opnd_i))
            else $error("rotate changed population count");
         // R8: rotate by a nonzero multiple of WIDTH is identity on data
         p_ror_mult_r8: assert (op_i != 2'b10 || amt_i == '0 || (int'(amt_i) % WIDTH) != 0
                                || result_o == opnd_i)
            else $error("rotate by full turns altered data");
         // R11: pass op leaves everything untouched
         p_pass_r11: assert (op_i != 2'b11 || (result_o == opnd_i && carry_o == carry_i))
            else $error("pass op altered data or carry");
      end
   end
endmodule

bind shc_shifter shc_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) chk_i (
   .opnd_i      (opnd_i),
   .amt_i       (amt_i),
   .op_i        (op_i),
   .carry_i     (carry_i),
   .flag_upd_i  (flag_upd_i),
   .result_o    (result_o),
   .carry_o     (carry_o),
   .carry_vld_o (carry_vld_o)
);

// File: tb/shc_shifter_tb_top.sv
`timescale 1ns/1ps
module shc_shifter_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opnd;
   logic [7:0]  amt;
   logic [1:0]  op;
   logic        cin;
   logic        upd;
   logic [31:0] res;
   logic        cout;
   logic        cvld;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   shc_shifter dut_i (
      .opnd_i      (opnd),
      .amt_i       (amt),
      .op_i        (op),
      .carry_i     (cin),
      .flag_upd_i  (upd),
      .result_o    (res),
      .carry_o     (cout),
      .carry_vld_o (cvld)
   );

   function automatic string tag_for(input int o, input int n, input bit u, input int kind);
      if (n == 0) return "R3";
      if (o == 3) return (kind == 2) ? "R10" : "R11";
      if (kind == 2) return "R10";
      if (kind == 1 && !u) return "R9";
      if (o == 2) return (n % 32 == 0) ? "R8" : "R7";
      if (n >= 33) return (kind == 0) ? "R4" : "R5";
      if (n == 32 && kind == 0) return "R4";
      if (o == 0) return (kind == 0) ? "R1" : "R2";
      return "R6";
   endfunction

   task automatic check_one(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s op=%0d amt=%0d upd=%0b: actual %h expected %h",
                  tag, what, op, amt, upd, act, exp);
      end
   endtask

   task automatic apply(input int o, input int n, input bit u, input bit c,
                        input logic [31:0] a);
      logic [31:0] er;
      logic        ec;
      logic        ev;
      int          m;
      @(posedge clk);
      #1;
      op = 2'(o); amt = 8'(n); upd = u; cin = c; opnd = a;
      // behavioural reference
      er = a;
      ec = c;
      ev = 1'b0;
      case (o)
         0: begin
            er = (n >= 32) ? 32'h0 : (a << n);
            if (n >= 1 && n <= 32) ec = a[32-n];
            else if (n > 32) ec = 1'b0;
         end
         1: begin
            er = (n >= 32) ? 32'h0 : (a >> n);
            if (n >= 1 && n <= 32) ec = a[n-1];
            else if (n > 32) ec = 1'b0;
         end
         2: begin
            m  = n % 32;
            er = (m == 0) ? a : ((a >> m) | (a << (32 - m)));
            if (n != 0) ec = a[(n + 31) % 32];
         end
         default: ;
      endcase
      if (u && n != 0 && o != 3) ev = 1'b1;
      else ec = c;
      @(negedge clk);
      check_one(tag_for(o, n, u, 0), "result", res, er);
      check_one(tag_for(o, n, u, 1), "carry", 32'(cout), 32'(ec));
      check_one(tag_for(o, n, u, 2), "carry_vld", 32'(cvld), 32'(ev));
   endtask

   initial begin
      logic [31:0] pats [5];
      opnd = '0; amt = '0; op = '0; cin = 1'b0; upd = 1'b0;
      pats[0] = 32'h0000_0000;
      pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h8000_0001;
      pats[3] = 32'hA5C3_1E69;
      pats[4] = $urandom;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R3: idle inputs give a zero result and no valid carry
      check_one("R3", "reset result", res, 32'h0);
      check_one("R3", "reset carry_vld", 32'(cvld), 32'h0);
      for (int o = 0; o < 4; o++)
         for (int u = 0; u < 2; u++)
            for (int p = 0; p < 5; p++)
               for (int n = 0; n < 256; n++)
                  apply(o, n, u[0], n[0] ^ p[0] ^ o[0], (p == 4) ? $urandom : pats[p]);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule